// File: doc/BRIEF.md
# Shared-Count Port Input Debouncer

This block cleans up the eight input pins of one port before they reach the input readback and the interrupt detectors. Each raw pin is first brought into the clock domain through a short synchronizer chain. Each pin then either passes straight through or goes through a glitch filter. The filter holds the last accepted level until the synchronized input has differed from it for a programmed number of millisecond ticks.

All pins of the port share one 8-bit tick count. Filtering is switched on per pin through a masked write, so one pin's setting can change without a read-modify-write. The millisecond strobe comes from outside as a one-cycle pulse. Each pin has its own tick counter, and it restarts whenever the synchronized input agrees with the accepted level again.

Top module: `dbc_port`

## Requirements
- R1: During reset the filtered outputs load from the synchronized inputs, and both the shared count and every per-pin filter enable are cleared to 0.
- R2: A cycle with `wr_cnt` high loads `wr_data[7:0]` as the shared tick count, which applies to every pin. The count is unchanged in any other cycle.
- R3: A cycle with `wr_ena` high updates the enable of pin i only when mask bit `wr_data[8+i]` is 1, and then sets it to `wr_data[i]`. Pins whose mask bit is 0 keep their enable. Enables are unchanged in any other cycle.
- R4: A pin whose enable is 0 bypasses the filter: its output follows the raw pin three clock edges later (two synchronizer stages plus the output register).
- R5: An enabled pin with a nonzero count N changes its output only at an edge where `tick_ms` is high. It takes the new level on the Nth tick counted while the synchronized input differs from the output.
- R6: If the synchronized input returns to the output level before the count is reached, the output does not change and that pin's tick counter restarts from zero.
- R7: With a count of 0, an enabled pin behaves like a bypassed pin and needs no tick.
- R8: A count write does not clear the per-pin tick counters. The new value is used at the next tick comparison, and a pin whose counter has already reached or passed it flips on that tick.
- R9: Pins are filtered independently of one another. Each keeps its own counter while they share the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| pins_raw | input | 8 | Raw asynchronous port pins |
| wr_cnt | input | 1 | Write strobe for the shared tick count |
| wr_ena | input | 1 | Write strobe for the masked enable update |
| wr_data | input | 16 | Write data: [15:8] mask, [7:0] values or count |
| pins_out | output | 8 | Filtered pin levels |

## Verification
The hardest state to reach from the ports is a pin whose counter is part-way to the count when the count is rewritten, or when the input bounces back. This needs ticks issued only after the synchronizer has settled and stopped at exact numbers. Directed sequences set up these cases: a glitch cut short after one tick, and a count lowered under a counter already at three. A long random phase then flips individual pins rarely and ticks often. That produces many overlapping part-way counts across pins, which are compared every cycle against a bench model.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_RESTART = 2'd1,
    ACT_COUNT   = 2'd2,
    ACT_FLIP    = 2'd3
  } pin_act_e;

  // true when one more tick brings the run to (or past) the limit
  function automatic logic run_done(input logic [15:0] run, input logic [15:0] lim);
    return (run + 16'd1) >= lim;
  endfunction

endpackage

// File: rtl/dbc_sync.sv
module dbc_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] st [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) st[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk) st[s] <= st[s-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/dbc_cfg.sv
module dbc_cfg #(
  parameter int NPINS = 8,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_cnt,
  input  logic               wr_ena,
  input  logic [2*NPINS-1:0] wr_data,
  output logic [NPINS-1:0]   en_o,
  output logic [CNT_W-1:0]   lim_o
);
  function automatic logic [NPINS-1:0] apply_mask(input logic [NPINS-1:0] cur,
                                                  input logic [2*NPINS-1:0] w);
    logic [NPINS-1:0] m;
    m = w[2*NPINS-1:NPINS];
    return (cur & ~m) | (w[NPINS-1:0] & m);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o  <= '0;
      lim_o <= '0;
    end else begin
      if (wr_ena) en_o  <= apply_mask(en_o, wr_data);
      if (wr_cnt) lim_o <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/dbc_pin.sv
module dbc_pin
  import dbc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [CNT_W-1:0] lim,
  input  logic             din,
  output logic             dout,
  output logic             flip_o
);
  logic             q;
  logic [CNT_W-1:0] run_q;
  pin_act_e         act;

  always_comb begin
    if (din == q)              act = ACT_RESTART;
    else if (!en)              act = ACT_FLIP;
    else if (lim == '0)        act = ACT_FLIP;
    else if (!tick)            act = ACT_HOLD;
    else if (run_done(16'(run_q), 16'(lim))) act = ACT_FLIP;
    else                       act = ACT_COUNT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= din;
      run_q <= '0;
    end else begin
      case (act)
        ACT_RESTART: run_q <= '0;
        ACT_COUNT:   run_q <= run_q + 1'b1;
        ACT_FLIP: begin
          q     <= din;
          run_q <= '0;
        end
        default: ;
      endcase
    end
  end

  assign dout   = q;
  assign flip_o = (act == ACT_FLIP);
endmodule

// File: rtl/dbc_port.sv
module dbc_port #(
  parameter int NPINS       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_ms,
  input  logic [NPINS-1:0]     pins_raw,
  input  logic                 wr_cnt,
  input  logic                 wr_ena,
  input  logic [2*NPINS-1:0]   wr_data,
  output logic [NPINS-1:0]     pins_out
);
  logic [NPINS-1:0] sync_v;
  logic [NPINS-1:0] en_q;
  logic [CNT_W-1:0] lim_q;
  logic [NPINS-1:0] flip_v;

  dbc_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pins_raw),
    .q   (sync_v)
  );

  dbc_cfg #(.NPINS(NPINS), .CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_cnt  (wr_cnt),
    .wr_ena  (wr_ena),
    .wr_data (wr_data),
    .en_o    (en_q),
    .lim_o   (lim_q)
  );

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      dbc_pin #(.CNT_W(CNT_W)) u_pin (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_ms),
        .en     (en_q[i]),
        .lim    (lim_q),
        .din    (sync_v[i]),
        .dout   (pins_out[i]),
        .flip_o (flip_v[i])
      );
    end
  endgenerate
endmodule

// File: rtl/dbc_port_chk.sv
module dbc_port_chk #(
  parameter int NPINS = 8,
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               wr_cnt,
  input logic               wr_ena,
  input logic [2*NPINS-1:0] wr_data,
  input logic [NPINS-1:0]   sync_v,
  input logic [NPINS-1:0]   en_q,
  input logic [CNT_W-1:0]   lim_q,
  input logic [NPINS-1:0]   flip_v,
  input logic [NPINS-1:0]   filt
);
  // R4
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((filt ^ $past(sync_v)) & ~$past(en_q)) == '0);

  // R5
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && lim_q != '0) |=> ((filt ^ $past(filt)) & $past(en_q)) == '0);

  // R6
  toward_input_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((filt ^ $past(filt)) & (filt ^ $past(sync_v))) == '0);

  // R9
  flip_event_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (filt ^ $past(filt)) == $past(flip_v & (sync_v ^ filt)));

  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ena |=> ((en_q ^ $past(en_q)) & ~$past(wr_data[2*NPINS-1:NPINS])) == '0);

  // R3
  en_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ena |=> $stable(en_q));

  // R2
  lim_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_cnt |=> $stable(lim_q));

  // R7
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (lim_q == '0) |=> filt == $past(sync_v));
endmodule

bind dbc_port dbc_port_chk #(.NPINS(NPINS), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick_ms),
  .wr_cnt  (wr_cnt),
  .wr_ena  (wr_ena),
  .wr_data (wr_data),
  .sync_v  (sync_v),
  .en_q    (en_q),
  .lim_q   (lim_q),
  .flip_v  (flip_v),
  .filt    (pins_out)
);

// File: tb/dbc_port_test.sv
`timescale 1ns/1ps
module dbc_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_ms = 1'b0;
  logic [7:0]  pins_raw = 8'hA5;
  logic        wr_cnt = 1'b0;
  logic        wr_ena = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  pins_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbc_port uut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .pins_raw(pins_raw),
    .wr_cnt(wr_cnt), .wr_ena(wr_ena), .wr_data(wr_data), .pins_out(pins_out)
  );

  // bench model, written from the requirements
  logic [7:0] m_s1, m_s2, m_out, m_en;
  int         m_lim;
  int         m_seen [8];

  function automatic logic [7:0] masked_update(logic [7:0] old, logic [15:0] w);
    logic [7:0] r;
    r = old;
    for (int b = 0; b < 8; b++) if (w[8+b]) r[b] = w[b];
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] nxt;
    #1;
    nxt = m_out;
    if (rst) begin
      nxt = m_s2;
      for (int b = 0; b < 8; b++) m_seen[b] = 0;
      m_en = '0;
      m_lim = 0;
    end else begin
      for (int b = 0; b < 8; b++) begin
        if (m_s2[b] == m_out[b]) m_seen[b] = 0;
        else if (!m_en[b] || m_lim == 0) begin
          nxt[b] = m_s2[b]; m_seen[b] = 0;
        end else if (tick_ms) begin
          m_seen[b]++;
          if (m_seen[b] >= m_lim) begin nxt[b] = m_s2[b]; m_seen[b] = 0; end
        end
      end
      if (wr_ena) m_en = masked_update(m_en, wr_data);
      if (wr_cnt) m_lim = int'(wr_data[7:0]);
    end
    m_out = nxt;
    m_s2 = m_s1;
    m_s1 = pins_raw;
    if (!rst) check("R9 model", pins_out, m_out);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick1();
    tick_ms = 1'b1; cyc(1); tick_ms = 1'b0;
  endtask

  task automatic set_cnt(logic [7:0] v);
    wr_cnt = 1'b1; wr_data = {8'h00, v}; cyc(1); wr_cnt = 1'b0;
  endtask

  task automatic set_en(logic [15:0] v);
    wr_ena = 1'b1; wr_data = v; cyc(1); wr_ena = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    check("R1 reset load", pins_out, 8'hA5);
    // R1 enables clear: pins follow directly
    pins_raw = 8'h5A; cyc(3);
    check("R1 enables off", pins_out, 8'h5A);
    // R4 latency
    pins_raw = 8'hFF; cyc(2);
    check("R4 before latency", pins_out, 8'h5A);
    cyc(1);
    check("R4 after latency", pins_out, 8'hFF);
    // R2 / R3
    set_cnt(8'd2);
    set_en(16'h0303);
    set_en(16'h0C0C);
    set_en(16'h0100);
    pins_raw = 8'h00; cyc(3);
    check("R3 masked enables", pins_out, 8'h0E);
    tick1();
    check("R5 one tick holds", pins_out, 8'h0E);
    tick1();
    check("R2 count two flips", pins_out, 8'h00);
    // R6 glitch restart
    pins_raw = 8'h0F; cyc(3);
    check("R6 setup", pins_out, 8'h01);
    tick1();
    pins_raw = 8'h00; cyc(3);
    check("R6 bounce back", pins_out, 8'h00);
    pins_raw = 8'h0F; cyc(3);
    tick1();
    check("R6 restarted", pins_out, 8'h01);
    tick1();
    check("R6 completes", pins_out, 8'h0F);
    // R8 count lowered under a running counter
    set_cnt(8'd4);
    pins_raw = 8'h00; cyc(3);
    tick1(); tick1(); tick1();
    check("R8 before rewrite", pins_out, 8'h0E);
    set_cnt(8'd2);
    check("R8 write alone", pins_out, 8'h0E);
    tick1();
    check("R8 counters kept", pins_out, 8'h00);
    // R7 zero count
    set_cnt(8'd0);
    pins_raw = 8'h0E; cyc(3);
    check("R7 zero count pass", pins_out, 8'h0E);
    // random phase, R9 via model
    void'($urandom(32'h5EED));
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] fl;
      fl = '0;
      for (int b = 0; b < 8; b++) if ($urandom_range(15) == 0) fl[b] = 1'b1;
      pins_raw = pins_raw ^ fl;
      tick_ms = ($urandom_range(2) == 0);
      wr_ena = ($urandom_range(49) == 0);
      wr_cnt = !wr_ena && ($urandom_range(99) == 0);
      wr_data = wr_cnt ? {8'h00, 8'($urandom_range(5))} : 16'($urandom);
      cyc(1);
    end
    tick_ms = 1'b0; wr_ena = 1'b0; wr_cnt = 1'b0;
    cyc(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule